// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the hazard control for an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. It reads the register numbers and write-enable flags held in the decode/execute, execute/memory and memory/writeback pipeline registers. From these it picks a bypass source for each ALU operand. It also decides when the front of the pipe must wait.

A load in execute whose destination feeds an operand of the instruction in decode raises a stall. The stall freezes the program counter and the fetch/decode register, and it sends one bubble into execute. The loaded value then reaches the ALU from the writeback stage. A branch taken in execute raises a flush, which turns the two younger instructions into NOPs. The decode, memory and writeback logic around the block supply its inputs and act on its outputs. All decisions are combinational. The clock and reset are used only by the embedded checks.

Top module: `hz_ctrl`

## Requirements
- R1: Each operand select uses these codes: 2'b00 takes the register file, 2'b10 takes the execute/memory result and 2'b01 takes the memory/writeback result. When no source matches, the code is 2'b00, and the code 2'b11 never appears.
- R2: When the execute/memory stage writes a nonzero register equal to an operand's source register in execute, that operand selects 2'b10.
- R3: When the memory/writeback stage writes a nonzero register equal to an operand's source register and the execute/memory stage does not, that operand selects 2'b01. When both stages match, 2'b10 wins.
- R4: A producing stage whose write enable is low never causes a forward or a stall.
- R5: Register 0 is never forwarded and never causes a stall.
- R6: A load in execute with its write enable high and a nonzero destination that equals either decode source register drives stall_o and idex_bubble_o high for that cycle. One cycle later, with the load in writeback and a bubble in execute/memory, the dependent operand selects 2'b01.
- R7: A non-load producer in execute that matches a decode source never stalls.
- R8: A taken branch in execute drives flush_o and idex_bubble_o high.
- R9: When a taken branch and a load-use hazard occur in the same cycle, flush_o is high and stall_o is low.
- R10: The two operand selects are decided independently. Each follows its own source register, even when the two sources are the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| id_rs1_i | input | 5 | First source register of the instruction in decode |
| id_rs2_i | input | 5 | Second source register of the instruction in decode |
| ex_rs1_i | input | 5 | First source register of the instruction in execute |
| ex_rs2_i | input | 5 | Second source register of the instruction in execute |
| ex_rd_i | input | 5 | Destination register of the instruction in execute |
| ex_we_i | input | 1 | Register write enable of the instruction in execute |
| ex_load_i | input | 1 | The instruction in execute is a load |
| ex_br_taken_i | input | 1 | A branch in execute resolved as taken |
| mem_rd_i | input | 5 | Destination register held in execute/memory |
| mem_we_i | input | 1 | Write enable held in execute/memory |
| wb_rd_i | input | 5 | Destination register held in memory/writeback |
| wb_we_i | input | 1 | Write enable held in memory/writeback |
| fwd_a_o | output | 2 | Bypass select for ALU operand A |
| fwd_b_o | output | 2 | Bypass select for ALU operand B |
| stall_o | output | 1 | Hold the PC and fetch/decode register |
| flush_o | output | 1 | Turn the fetch/decode contents into a NOP |
| idex_bubble_o | output | 1 | Load a NOP into decode/execute |

## Verification
Two pairs of decisions can fall due in the same cycle. The first is a taken branch together with a load-use match: the bench drives a loading execute stage whose destination matches a decode source while the branch-taken flag is high, and it expects a flush with no stall. The second is both later stages matching one execute source register: the bench gives the execute/memory and memory/writeback stages the same destination with both write enables high, and it expects the execute/memory code. The bench varies the write enables and uses register 0 so that each side of both priorities is covered.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned NUM_OPS = 2;

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_EXM = 2'b10;
  localparam logic [1:0] SEL_MWB = 2'b01;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic          mwb_we_i,
  output logic [1:0]    sel_o
);
  localparam logic [AW-1:0] ZERO = '0;

  logic exm_hit, mwb_hit;

  assign exm_hit = exm_we_i && (exm_rd_i != ZERO) && (exm_rd_i == src_i);
  assign mwb_hit = mwb_we_i && (mwb_rd_i != ZERO) && (mwb_rd_i == src_i);

  // younger producer wins
  always_comb begin
    if (exm_hit)      sel_o = SEL_EXM;
    else if (mwb_hit) sel_o = SEL_MWB;
    else              sel_o = SEL_RF;
  end

  assert_sel_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != 2'b11);
  assert_exm_prio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exm_we_i && mwb_we_i && exm_rd_i == mwb_rd_i && src_i == exm_rd_i
     && src_i != ZERO) |-> sel_o == SEL_EXM);
  assert_no_we_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exm_we_i && !mwb_we_i) |-> sel_o == SEL_RF);
  assert_reg0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == ZERO) |-> sel_o == SEL_RF);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
#(
  parameter int unsigned AW   = REG_AW,
  parameter int unsigned NSRC = NUM_OPS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NSRC-1:0][AW-1:0] id_src_i,
  input  logic [AW-1:0]        ex_rd_i,
  input  logic                 ex_we_i,
  input  logic                 ex_load_i,
  output logic                 hazard_o
);
  localparam logic [AW-1:0] ZERO = '0;

  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = id_src_i[g] == ex_rd_i;
  end

  assign hazard_o = ex_load_i && ex_we_i && (ex_rd_i != ZERO) && (|hit);

  assert_load_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_load_i |-> !hazard_o);
  assert_no_we_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_we_i |-> !hazard_o);
  assert_reg0_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == ZERO) |-> !hazard_o);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic              ex_br_taken_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              stall_o,
  output logic              flush_o,
  output logic              idex_bubble_o
);
  logic [NUM_OPS-1:0][REG_AW-1:0] ex_src, id_src;
  logic [NUM_OPS-1:0][1:0]        sel;
  logic                           lu_hazard;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_fwd_sel #(.AW(REG_AW)) u_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (ex_src[g]),
      .exm_rd_i (mem_rd_i),
      .exm_we_i (mem_we_i),
      .mwb_rd_i (wb_rd_i),
      .mwb_we_i (wb_we_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  hz_load_use #(.AW(REG_AW), .NSRC(NUM_OPS)) u_lu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_src_i  (id_src),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .hazard_o  (lu_hazard)
  );

  // a taken branch discards the stalled instruction anyway
  assign flush_o       = ex_br_taken_i;
  assign stall_o       = lu_hazard && !ex_br_taken_i;
  assign idex_bubble_o = lu_hazard || ex_br_taken_i;

  assert_flush_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !stall_o);
  assert_branch_bubble_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_br_taken_i |-> (flush_o && idex_bubble_o));
  assert_stall_bubble_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> idex_bubble_o);
  assert_same_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_i == ex_rs2_i) |-> (fwd_a_o == fwd_b_o));
endmodule

// File: tb/tb_hz_ctrl.sv
module tb_hz_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
  logic [4:0] mem_rd = '0, wb_rd = '0;
  logic ex_we = 1'b0, ex_ld = 1'b0, br = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
  logic [1:0] fwd_a, fwd_b;
  logic stall, flush, bub;

  hz_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
    .ex_we_i(ex_we), .ex_load_i(ex_ld), .ex_br_taken_i(br),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .flush_o(flush),
    .idex_bubble_o(bub)
  );

  typedef struct packed {
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd;
    logic       ex_we, ex_ld, br;
    logic [4:0] mem_rd;
    logic       mem_we;
    logic [4:0] wb_rd;
    logic       wb_we;
    logic [1:0] ea, eb;
    logic       es, ef, ebub;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // idle: R1
    '{5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b0,1'b0, 5'd0,1'b0, 5'd0,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0, 4'd1},
    // R2 exm forward on A
    '{5'd0,5'd0,5'd3,5'd0,5'd0, 1'b0,1'b0,1'b0, 5'd3,1'b1, 5'd0,1'b0, 2'b10,2'b00, 1'b0,1'b0,1'b0, 4'd2},
    // R3 mwb forward on B
    '{5'd0,5'd0,5'd0,5'd4,5'd0, 1'b0,1'b0,1'b0, 5'd0,1'b0, 5'd4,1'b1, 2'b00,2'b01, 1'b0,1'b0,1'b0, 4'd3},
    // R3 both match, exm wins
    '{5'd0,5'd0,5'd5,5'd0,5'd0, 1'b0,1'b0,1'b0, 5'd5,1'b1, 5'd5,1'b1, 2'b10,2'b00, 1'b0,1'b0,1'b0, 4'd3},
    // R4 no write enables
    '{5'd0,5'd0,5'd6,5'd6,5'd0, 1'b0,1'b0,1'b0, 5'd6,1'b0, 5'd6,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0, 4'd4},
    // R4 exm disabled, mwb enabled
    '{5'd0,5'd0,5'd7,5'd0,5'd0, 1'b0,1'b0,1'b0, 5'd7,1'b0, 5'd7,1'b1, 2'b01,2'b00, 1'b0,1'b0,1'b0, 4'd4},
    // R5 register 0 everywhere
    '{5'd0,5'd0,5'd0,5'd0,5'd0, 1'b1,1'b1,1'b0, 5'd0,1'b1, 5'd0,1'b1, 2'b00,2'b00, 1'b0,1'b0,1'b0, 4'd5},
    // R6 load-use via id rs2
    '{5'd0,5'd8,5'd0,5'd0,5'd8, 1'b1,1'b1,1'b0, 5'd0,1'b0, 5'd0,1'b0, 2'b00,2'b00, 1'b1,1'b0,1'b1, 4'd6},
    // R6 load-use via id rs1
    '{5'd9,5'd0,5'd0,5'd0,5'd9, 1'b1,1'b1,1'b0, 5'd0,1'b0, 5'd0,1'b0, 2'b00,2'b00, 1'b1,1'b0,1'b1, 4'd6},
    // R7 ALU producer, no stall
    '{5'd10,5'd0,5'd0,5'd0,5'd10, 1'b1,1'b0,1'b0, 5'd0,1'b0, 5'd0,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0, 4'd7},
    // R4 load without write enable
    '{5'd10,5'd0,5'd0,5'd0,5'd10, 1'b0,1'b1,1'b0, 5'd0,1'b0, 5'd0,1'b0, 2'b00,2'b00, 1'b0,1'b0,1'b0, 4'd4},
    // R8 taken branch
    '{5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b0,1'b1, 5'd0,1'b0, 5'd0,1'b0, 2'b00,2'b00, 1'b0,1'b1,1'b1, 4'd8},
    // R9 branch and load-use together
    '{5'd11,5'd0,5'd0,5'd0,5'd11, 1'b1,1'b1,1'b1, 5'd0,1'b0, 5'd0,1'b0, 2'b00,2'b00, 1'b0,1'b1,1'b1, 4'd9},
    // R10 independent operands
    '{5'd0,5'd0,5'd12,5'd13,5'd0, 1'b0,1'b0,1'b0, 5'd12,1'b1, 5'd13,1'b1, 2'b10,2'b01, 1'b0,1'b0,1'b0, 4'd10},
    // R10 same source on both operands
    '{5'd0,5'd0,5'd14,5'd14,5'd0, 1'b0,1'b0,1'b0, 5'd14,1'b1, 5'd0,1'b0, 2'b10,2'b10, 1'b0,1'b0,1'b0, 4'd10}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string what, input int req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    id_rs1 = v.id_rs1; id_rs2 = v.id_rs2; ex_rs1 = v.ex_rs1; ex_rs2 = v.ex_rs2;
    ex_rd = v.ex_rd; ex_we = v.ex_we; ex_ld = v.ex_ld; br = v.br;
    mem_rd = v.mem_rd; mem_we = v.mem_we; wb_rd = v.wb_rd; wb_we = v.wb_we;
  endtask

  task automatic judge(input vec_t v);
    chk("fwd_a", int'(v.req), int'(fwd_a), int'(v.ea));
    chk("fwd_b", int'(v.req), int'(fwd_b), int'(v.eb));
    chk("stall", int'(v.req), int'(stall), int'(v.es));
    chk("flush", int'(v.req), int'(flush), int'(v.ef));
    chk("bubble", int'(v.req), int'(bub), int'(v.ebub));
  endtask

  initial begin
    vec_t v;
    // reset state: idle inputs give no forward, stall or flush (R1)
    repeat (2) @(negedge clk);
    #2;
    chk("reset fwd_a", 1, int'(fwd_a), 0);
    chk("reset stall", 1, int'(stall), 0);
    chk("reset bubble", 1, int'(bub), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #2;
      judge(VECS[i]);
    end

    // R6 follow-up: load now in writeback, bubble in execute/memory
    @(negedge clk);
    v = '0;
    v.id_rs1 = 5'd8; v.ex_rs1 = 5'd8; v.wb_rd = 5'd8; v.wb_we = 1'b1;
    v.ea = 2'b01; v.req = 4'd6;
    drive(v);
    #2;
    judge(v);

    // R3 across a sequence: exm switches off, mwb takes over on the next cycle
    @(negedge clk);
    v = '0;
    v.ex_rs2 = 5'd20; v.mem_rd = 5'd20; v.mem_we = 1'b1; v.wb_rd = 5'd20; v.wb_we = 1'b1;
    v.eb = 2'b10; v.req = 4'd3;
    drive(v);
    #2;
    judge(v);
    @(negedge clk);
    v.mem_we = 1'b0; v.eb = 2'b01;
    drive(v);
    #2;
    judge(v);

    // R9 branch clears, load-use stall appears
    @(negedge clk);
    v = '0;
    v.id_rs2 = 5'd31; v.ex_rd = 5'd31; v.ex_we = 1'b1; v.ex_ld = 1'b1; v.br = 1'b1;
    v.ef = 1'b1; v.ebub = 1'b1; v.req = 4'd9;
    drive(v);
    #2;
    judge(v);
    @(negedge clk);
    v.br = 1'b0; v.ef = 1'b0; v.es = 1'b1;
    drive(v);
    #2;
    judge(v);

    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule